// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Nesting Levels

This block arbitrates a configurable set of interrupt lines for a small processor core. Lines carry vector numbers starting at 16. Each line has an enable bit, a priority from 0 (most urgent) to a configured maximum, a trigger mode (level or pulse), and a pending flag. Software reaches one line at a time through a line-select register and then reads or writes that line's fields through a small set of register addresses.

The controller tracks which priority levels are in service in an active register. It holds one bit per level and a saved user-mode flag. A new interrupt is accepted only when the core allows it and when the most urgent pending level is strictly more urgent than the most urgent level in service. On acceptance it raises a one-cycle strobe with the vector number and the handler-table address. In the same clock edge it marks the level active and stores the vector as that level's cause. A return pulse from the core retires the most urgent active level.

Top module: `irq_prio_ctrl`

## Requirements
- R1: The select register resets to 16. A write to it (address 0) takes effect only if the value is at most 16 plus NUM_LINES; a larger value is ignored. Per-line reads while no existing line is selected return 0.
- R2: The active register (address 6) holds level bits in [15:0] and a saved user flag in bit 31. A write keeps only the bits of mask 0x8000FFFF. When a level is accepted while no level bit is set, bit 31 takes the value of cpu_user; otherwise bit 31 is left unchanged.
- R3: A pending line is accepted only if its priority is strictly lower in number than the lowest set bit of active[15:0]. With no active level, any priority qualifies. An equal priority never preempts.
- R4: No interrupt is accepted while cpu_ie is low, or while cpu_halt, cpu_exc or cpu_dslot is high, or when the most urgent pending enabled priority exceeds cpu_thresh.
- R5: Among enabled pending lines, the lowest priority number wins. Within that priority, the lowest vector wins.
- R6: An acceptance decided in one cycle gives take high for exactly the next cycle. take_vec then carries the vector, and take_addr carries the vector base (address 9) plus 4 times the vector. At the same edge the winning level's bit is set in the active register.
- R7: A status read (address 5) returns priority in [3:0], enable in bit 4, trigger (1 = pulse) in bit 5 and pending in bit 31. Addresses 1, 2 and 3 read and write priority, trigger and enable. A priority write above MAX_LEVEL is ignored. After reset every line is enabled, at priority 0, and level-triggered.
- R8: The control register (address 7) stores only the bits of mask 0x2E1F.
- R9: A level-triggered line's pending flag follows its input. A pulse-triggered line's pending flag sets on a rising input edge. It stays set until a cancel write (address 4) or until that line is accepted. A cancel write has no effect on a level-triggered line.
- R10: A cause read (address 8) returns 0 when active[15:0] is zero. Otherwise it returns the vector stored for the lowest set active bit. A return pulse (rtie) clears that bit. If an acceptance falls in the same cycle, both updates apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | Interrupt inputs, bit i is vector 16+i |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cpu_ie | input | 1 | Global interrupt enable |
| cpu_halt | input | 1 | Core halted |
| cpu_exc | input | 1 | Core in exception handling |
| cpu_dslot | input | 1 | Core in a delay slot |
| cpu_user | input | 1 | Core in user mode |
| cpu_thresh | input | 4 | Highest priority number that may be taken |
| rtie | input | 1 | Return-from-interrupt pulse |
| take | output | 1 | Acceptance strobe |
| take_vec | output | VEC_W | Accepted vector number |
| take_addr | output | 32 | Handler table address |

## Verification
An acceptance and a return pulse can fall in the same cycle. The active register must then drop the level being retired and gain the new, more urgent level, and neither update may mask the other. The bench provokes this by holding one level active, then raising a more urgent level input on the same cycle as rtie. It then expects a strobe for the new vector, an active value holding only the new level bit, and a cause read naming the new vector.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int FIRST_LINE = 16;
   localparam int LEVELS     = 16;
   localparam logic [31:0] CTRL_KEEP = 32'h0000_2E1F;
   localparam logic [31:0] ACT_KEEP  = 32'h8000_FFFF;

   typedef enum logic [3:0] {
      RA_SEL    = 4'd0,
      RA_PRIO   = 4'd1,
      RA_TRIG   = 4'd2,
      RA_ENA    = 4'd3,
      RA_CANCEL = 4'd4,
      RA_STAT   = 4'd5,
      RA_ACT    = 4'd6,
      RA_CTRL   = 4'd7,
      RA_CAUSE  = 4'd8,
      RA_VBASE  = 4'd9
   } reg_addr_e;

   // index of lowest set bit, 16 when none set
   function automatic logic [4:0] lowest16(input logic [15:0] v);
      logic [4:0] r;
      r = 5'd16;
      for (int i = 15; i >= 0; i--) begin
         if (v[i]) r = 5'(i);
      end
      return r;
   endfunction
endpackage

// File: rtl/irqc_line.sv
module irqc_line #(
   parameter int MAX_LEVEL = 7
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        irq,
   input  logic        we_prio,
   input  logic        we_trig,
   input  logic        we_ena,
   input  logic        we_cancel,
   input  logic [31:0] wval,
   input  logic        ack,
   output logic [3:0]  prio,
   output logic        ena,
   output logic        trig,
   output logic        pend
);
   logic irq_prev;
   logic pulse_q;
   logic rise;

   assign rise = irq & ~irq_prev;
   assign pend = trig ? pulse_q : irq;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prio     <= 4'd0;
         ena      <= 1'b1;
         trig     <= 1'b0;
         pulse_q  <= 1'b0;
         irq_prev <= 1'b0;
      end else begin
         irq_prev <= irq;
         if (we_prio && wval <= 32'(MAX_LEVEL)) prio <= wval[3:0];
         if (we_ena)  ena  <= wval[0];
         if (we_trig) trig <= wval[0];
         if (!trig)                 pulse_q <= 1'b0;
         else if (rise)             pulse_q <= 1'b1;
         else if (ack || we_cancel) pulse_q <= 1'b0;
      end
   end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
   parameter int N     = 8,
   parameter int IDX_W = 3
) (
   input  logic [N-1:0]   req,
   input  logic [N*4-1:0] prio_flat,
   output logic [15:0]    pmask,
   output logic [4:0]     win_prio,
   output logic [IDX_W-1:0] win_idx
);
   import irqc_pkg::*;

   always_comb begin
      pmask = '0;
      for (int i = 0; i < N; i++) begin
         if (req[i]) pmask[prio_flat[i*4 +: 4]] = 1'b1;
      end
   end

   assign win_prio = lowest16(pmask);

   always_comb begin
      win_idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i] && {1'b0, prio_flat[i*4 +: 4]} == win_prio) win_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
   parameter int NUM_LINES = 8,
   parameter int MAX_LEVEL = 7,
   parameter int VEC_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_in,
   input  logic                 reg_we,
   input  logic [3:0]           reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic                 cpu_ie,
   input  logic                 cpu_halt,
   input  logic                 cpu_exc,
   input  logic                 cpu_dslot,
   input  logic                 cpu_user,
   input  logic [3:0]           cpu_thresh,
   input  logic                 rtie,
   output logic                 take,
   output logic [VEC_W-1:0]     take_vec,
   output logic [31:0]          take_addr
);
   import irqc_pkg::*;

   localparam int IDX_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
   localparam int SEL_MAX = FIRST_LINE + NUM_LINES;

   if (NUM_LINES < 1 || SEL_MAX > (2 ** VEC_W) - 1) begin : g_bad_lines
      $error("irq_prio_ctrl: NUM_LINES does not fit VEC_W");
   end
   if (MAX_LEVEL < 0 || MAX_LEVEL >= LEVELS) begin : g_bad_level
      $error("irq_prio_ctrl: MAX_LEVEL out of range");
   end

   logic [VEC_W-1:0]   sel_q;
   logic [31:0]        act_q, act_d;
   logic [31:0]        ctrl_q, vbase_q;
   logic [VEC_W-1:0]   cause_q [LEVELS];

   logic [NUM_LINES-1:0]   hit, req, ack;
   logic [NUM_LINES-1:0]   l_ena, l_trig, l_pend;
   logic [NUM_LINES*4-1:0] l_prio;
   logic [15:0]            pmask;
   logic [4:0]             win_prio, act_lo;
   logic [IDX_W-1:0]       win_idx;
   logic [VEC_W-1:0]       win_vec;
   logic                   go;

   logic wr_sel, wr_prio, wr_trig, wr_ena, wr_cancel, wr_act, wr_ctrl, wr_vbase;
   assign wr_sel    = reg_we && reg_addr == RA_SEL;
   assign wr_prio   = reg_we && reg_addr == RA_PRIO;
   assign wr_trig   = reg_we && reg_addr == RA_TRIG;
   assign wr_ena    = reg_we && reg_addr == RA_ENA;
   assign wr_cancel = reg_we && reg_addr == RA_CANCEL;
   assign wr_act    = reg_we && reg_addr == RA_ACT;
   assign wr_ctrl   = reg_we && reg_addr == RA_CTRL;
   assign wr_vbase  = reg_we && reg_addr == RA_VBASE;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      assign hit[i] = (sel_q == VEC_W'(FIRST_LINE + i));
      assign ack[i] = go && (win_idx == IDX_W'(i));
      assign req[i] = l_ena[i] & l_pend[i];
      irqc_line #(.MAX_LEVEL(MAX_LEVEL)) u_line (
         .clk      (clk),
         .rst_n    (rst_n),
         .irq      (irq_in[i]),
         .we_prio  (wr_prio && hit[i]),
         .we_trig  (wr_trig && hit[i]),
         .we_ena   (wr_ena && hit[i]),
         .we_cancel(wr_cancel && hit[i]),
         .wval     (reg_wdata),
         .ack      (ack[i]),
         .prio     (l_prio[i*4 +: 4]),
         .ena      (l_ena[i]),
         .trig     (l_trig[i]),
         .pend     (l_pend[i])
      );
   end

   irqc_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_pick (
      .req      (req),
      .prio_flat(l_prio),
      .pmask    (pmask),
      .win_prio (win_prio),
      .win_idx  (win_idx)
   );

   assign act_lo  = lowest16(act_q[15:0]);
   assign win_vec = VEC_W'(FIRST_LINE) + VEC_W'(win_idx);
   assign go = cpu_ie && !cpu_halt && !cpu_exc && !cpu_dslot && (pmask != '0)
               && (win_prio < act_lo) && (win_prio <= {1'b0, cpu_thresh});

   always_comb begin
      act_d = act_q;
      if (wr_act) begin
         act_d = reg_wdata & ACT_KEEP;
      end else begin
         if (rtie && act_lo != 5'd16) act_d[act_lo[3:0]] = 1'b0;
         if (go) begin
            if (act_q[15:0] == '0) act_d[31] = cpu_user;
            act_d[win_prio[3:0]] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q     <= VEC_W'(FIRST_LINE);
         act_q     <= '0;
         ctrl_q    <= '0;
         vbase_q   <= '0;
         take      <= 1'b0;
         take_vec  <= '0;
         take_addr <= '0;
         for (int k = 0; k < LEVELS; k++) cause_q[k] <= '0;
      end else begin
         if (wr_sel && reg_wdata <= 32'(SEL_MAX)) sel_q <= reg_wdata[VEC_W-1:0];
         if (wr_ctrl)  ctrl_q  <= reg_wdata & CTRL_KEEP;
         if (wr_vbase) vbase_q <= reg_wdata;
         act_q     <= act_d;
         take      <= go;
         take_vec  <= win_vec;
         take_addr <= vbase_q + (32'(win_vec) << 2);
         if (go) cause_q[win_prio[3:0]] <= win_vec;
      end
   end

   // read mux
   logic [3:0] s_prio;
   logic       s_ena, s_trig, s_pend;
   always_comb begin
      s_prio = '0; s_ena = 1'b0; s_trig = 1'b0; s_pend = 1'b0;
      for (int i = 0; i < NUM_LINES; i++) begin
         if (hit[i]) begin
            s_prio = l_prio[i*4 +: 4];
            s_ena  = l_ena[i];
            s_trig = l_trig[i];
            s_pend = l_pend[i];
         end
      end
   end

   always_comb begin
      case (reg_addr)
         RA_SEL:   reg_rdata = 32'(sel_q);
         RA_PRIO:  reg_rdata = 32'(s_prio);
         RA_TRIG:  reg_rdata = 32'(s_trig);
         RA_ENA:   reg_rdata = 32'(s_ena);
         RA_STAT:  reg_rdata = {s_pend, 25'd0, s_trig, s_ena, s_prio};
         RA_ACT:   reg_rdata = act_q;
         RA_CTRL:  reg_rdata = ctrl_q;
         RA_CAUSE: reg_rdata = (act_lo == 5'd16) ? 32'd0 : 32'(cause_q[act_lo[3:0]]);
         RA_VBASE: reg_rdata = vbase_q;
         default:  reg_rdata = 32'd0;
      endcase
   end
endmodule

// File: rtl/irqc_checks.sv
module irqc_checks #(
   parameter int NUM_LINES = 8,
   parameter int VEC_W     = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             take,
   input logic [VEC_W-1:0] take_vec,
   input logic             cpu_ie,
   input logic             cpu_halt,
   input logic             cpu_exc,
   input logic             cpu_dslot,
   input logic [31:0]      act_q,
   input logic [VEC_W-1:0] sel_q,
   input logic [3:0]       reg_addr,
   input logic [31:0]      reg_rdata
);
   import irqc_pkg::*;

   a_r1_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
      32'(sel_q) <= 32'(FIRST_LINE + NUM_LINES));

   a_r2_act_reserved: assert property (@(posedge clk) disable iff (!rst_n)
      act_q[30:16] == '0);

   a_r4_take_gated: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> $past(cpu_ie && !cpu_halt && !cpu_exc && !cpu_dslot));

   a_r6_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> (32'(take_vec) >= 32'(FIRST_LINE) && 32'(take_vec) < 32'(FIRST_LINE + NUM_LINES)));

   a_r6_level_marked: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> act_q[15:0] != '0);

   a_r10_cause_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == RA_CAUSE && act_q[15:0] == '0) |-> reg_rdata == '0);
endmodule

bind irq_prio_ctrl irqc_checks #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .take     (take),
   .take_vec (take_vec),
   .cpu_ie   (cpu_ie),
   .cpu_halt (cpu_halt),
   .cpu_exc  (cpu_exc),
   .cpu_dslot(cpu_dslot),
   .act_q    (act_q),
   .sel_q    (sel_q),
   .reg_addr (reg_addr),
   .reg_rdata(reg_rdata)
);

// File: tb/irq_prio_ctrl_tb.sv
module irq_prio_ctrl_tb;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] irq_in = '0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        cpu_ie = 1'b0, cpu_halt = 1'b0, cpu_exc = 1'b0, cpu_dslot = 1'b0;
   logic        cpu_user = 1'b0;
   logic [3:0]  cpu_thresh = 4'd15;
   logic        rtie = 1'b0;
   logic        take;
   logic [7:0]  take_vec;
   logic [31:0] take_addr;

   int total = 0;
   int bad = 0;
   int take_seen = 0;
   bit done = 0;
   int exp_vec_q[$];
   logic [31:0] exp_addr_q[$];

   always #4 clk = ~clk;

   irq_prio_ctrl #(.NUM_LINES(N), .MAX_LEVEL(7), .VEC_W(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .cpu_ie(cpu_ie), .cpu_halt(cpu_halt), .cpu_exc(cpu_exc),
      .cpu_dslot(cpu_dslot), .cpu_user(cpu_user), .cpu_thresh(cpu_thresh),
      .rtie(rtie), .take(take), .take_vec(take_vec), .take_addr(take_addr));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input string req, input logic [3:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic expect_take(input int vec);
      exp_vec_q.push_back(vec);
      exp_addr_q.push_back(32'h1000 + 32'(vec) * 4);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ret_pulse();
      @(negedge clk); rtie = 1'b1;
      @(negedge clk); rtie = 1'b0;
   endtask

   // monitor: compare strobes against the scoreboard
   always @(negedge clk) begin
      if (rst_n && take) begin
         take_seen++;
         if (exp_vec_q.size() == 0) begin
            check("R3/R4 unexpected take", {24'd0, take_vec}, 32'hFFFF_FFFF);
         end else begin
            check("R5/R6 take_vec", {24'd0, take_vec}, 32'(exp_vec_q.pop_front()));
            check("R6 take_addr", take_addr, exp_addr_q.pop_front());
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int seen0;
      idle(5);
      rst_n = 1'b1;
      // reset state
      rd("R1 select reset", 4'd0, 32'd16);
      rd("R2 active reset", 4'd6, 32'd0);
      rd("R10 cause idle", 4'd8, 32'd0);
      check("R6 take idle", {31'd0, take}, 32'd0);

      cpu_ie = 1'b1; cpu_thresh = 4'd15; cpu_user = 1'b1;
      wr(4'd9, 32'h1000);
      rd("R7 reset status", 4'd5, 32'h10);
      wr(4'd1, 32'd3);
      rd("R7 status layout", 4'd5, 32'h13);
      wr(4'd1, 32'd9);
      rd("R7 priority reject", 4'd1, 32'd3);
      wr(4'd0, 32'd25);
      rd("R1 select reject", 4'd0, 32'd16);
      wr(4'd0, 32'd24);
      rd("R1 select limit", 4'd0, 32'd24);
      rd("R1 no line status", 4'd5, 32'd0);
      wr(4'd7, 32'hFFFF_FFFF);
      rd("R8 control mask", 4'd7, 32'h2E1F);
      wr(4'd6, 32'hFFFF_FFFF);
      rd("R2 active mask", 4'd6, 32'h8000_FFFF);
      wr(4'd6, 32'd0);
      // line setup
      wr(4'd0, 32'd18); wr(4'd1, 32'd1);
      wr(4'd0, 32'd19); wr(4'd1, 32'd3);
      wr(4'd0, 32'd17); wr(4'd1, 32'd2);
      wr(4'd0, 32'd21); wr(4'd1, 32'd2);
      wr(4'd0, 32'd20); wr(4'd2, 32'd1); wr(4'd1, 32'd5); wr(4'd3, 32'd0);

      // first acceptance
      expect_take(16);
      irq_in[0] = 1'b1; idle(3);
      rd("R2 user saved", 4'd6, 32'h8000_0008);
      rd("R6 cause recorded", 4'd8, 32'd16);

      // equal priority does not preempt
      seen0 = take_seen;
      irq_in[3] = 1'b1; idle(4);
      check("R3 equal no preempt", 32'(take_seen), 32'(seen0));

      // more urgent preempts
      expect_take(18);
      irq_in[2] = 1'b1; idle(3);
      rd("R3 nested active", 4'd6, 32'h8000_000A);
      rd("R10 cause lowest", 4'd8, 32'd18);

      // returns
      irq_in[2] = 1'b0;
      seen0 = take_seen;
      ret_pulse(); idle(2);
      rd("R10 return clears lowest", 4'd6, 32'h8000_0008);
      rd("R10 cause after return", 4'd8, 32'd16);
      check("R3 no retake equal", 32'(take_seen), 32'(seen0));
      irq_in[0] = 1'b0; irq_in[3] = 1'b0;
      ret_pulse();
      rd("R10 cause none", 4'd8, 32'd0);
      wr(4'd6, 32'd0);

      // gating
      cpu_user = 1'b0;
      seen0 = take_seen;
      cpu_ie = 1'b0; irq_in[0] = 1'b1; idle(3);
      cpu_ie = 1'b1; cpu_dslot = 1'b1; idle(3);
      cpu_dslot = 1'b0; cpu_halt = 1'b1; idle(3);
      cpu_halt = 1'b0; cpu_exc = 1'b1; idle(3);
      cpu_exc = 1'b0; cpu_thresh = 4'd2; idle(3);
      check("R4 gates block", 32'(take_seen), 32'(seen0));
      expect_take(16);
      cpu_thresh = 4'd15; idle(3);
      rd("R2 user clear", 4'd6, 32'h0000_0008);
      irq_in[0] = 1'b0;
      ret_pulse();
      rd("R10 all returned", 4'd6, 32'd0);

      // lowest line within a level
      expect_take(17);
      irq_in[1] = 1'b1; irq_in[5] = 1'b1; idle(3);
      seen0 = take_seen;
      irq_in[1] = 1'b0; idle(3);
      check("R5 lowest line only", 32'(take_seen), 32'(seen0));
      irq_in[5] = 1'b0;
      ret_pulse();

      // pulse lines and cancel
      cpu_ie = 1'b0;
      irq_in[4] = 1'b1; idle(1); irq_in[4] = 1'b0; idle(2);
      wr(4'd0, 32'd20);
      rd("R9 pulse held", 4'd5, 32'h8000_0025);
      wr(4'd4, 32'd0);
      rd("R9 pulse cancel", 4'd5, 32'h0000_0025);
      irq_in[0] = 1'b1;
      wr(4'd0, 32'd16); wr(4'd4, 32'd0);
      rd("R9 level ignores cancel", 4'd5, 32'h8000_0013);
      irq_in[0] = 1'b0;
      cpu_ie = 1'b1;
      wr(4'd0, 32'd20); wr(4'd3, 32'd1);
      expect_take(20);
      irq_in[4] = 1'b1; idle(1); irq_in[4] = 1'b0; idle(3);
      rd("R9 ack clears pulse", 4'd5, 32'h0000_0035);
      rd("R6 pulse level active", 4'd6, 32'h0000_0020);

      // accept and return in the same cycle
      expect_take(18);
      @(negedge clk); irq_in[2] = 1'b1; rtie = 1'b1;
      @(negedge clk); rtie = 1'b0;
      idle(2);
      rd("R10 same-cycle accept and return", 4'd6, 32'h0000_0002);
      rd("R10 same-cycle cause", 4'd8, 32'd18);
      irq_in[2] = 1'b0;
      ret_pulse(); idle(2);
      rd("R10 final idle", 4'd6, 32'd0);
      check("R6 all strobes seen", 32'(exp_vec_q.size()), 32'd0);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule